// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Probe

This block holds a small, fully associative table of address-translation entries. Software fills and inspects it through a handful of coprocessor-style registers: a key register holding the virtual page number and address-space ID, two page-descriptor registers (one for the even page and one for the odd page of a pair), a page-size mask, a slot-index register and a free-running victim counter. Software loads the registers and then issues one of four commands: write the slot named by the index register, write the slot named by the victim counter, search the table for the key, or read a slot back into the registers.

Each entry maps an even/odd page pair. It stores a virtual page number, an 8-bit address-space ID, a shared global bit and, for each of its two pages, a frame number, a 3-bit cache attribute, a dirty bit and a valid bit. A search scans the slots in ascending order, one slot per cycle, and stops at the first match. A hit stores the slot number in the index register. A miss sets the index register's top bit.

Control is a five-state machine. `ST_IDLE` accepts a command when `cmd_valid` is high, and it is the only state in which register writes take effect. `ST_IDLE` moves to `ST_WRITE` for either write command, to `ST_READ` for a read and to `ST_SCAN` for a search. `ST_WRITE` and `ST_READ` always go to `ST_FIN`. `ST_SCAN` goes to `ST_FIN` on a hit or after the last slot, and otherwise stays to test the next slot. `ST_FIN` raises `cmd_done` for one cycle and returns to `ST_IDLE`.

Top module: `soft_tlb_ctl`

## Requirements
- R1: After reset, the index register reads 0x8000_0000, the victim counter reads NUM_ENTRIES-1, and every slot reads back as all zeros, so its global and valid bits are 0.
- R2: The victim counter decrements once per cycle from NUM_ENTRIES-1 down to RAND_FLOOR, then reloads NUM_ENTRIES-1. Register writes to it (select 5) have no effect.
- R3: A write stores the VPN as key bits 31:13 and the ASID as key bits 7:0. The stored global bit is bit 0 of the even descriptor ANDed with bit 0 of the odd descriptor.
- R4: In each page descriptor, bit 1 is valid, bit 2 is dirty, bits 5:3 are the cache attribute and bits 31:6 are the frame number. All of these are stored per page.
- R5: The write-by-victim command (op 1) uses the value the victim counter holds in the cycle the command is accepted.
- R6: The read command (op 3) sets the key register to VPN<<13 | ASID, with bits 12:8 cleared. Each descriptor becomes {frame, cache, dirty, valid, global}, and the slot's page mask is restored.
- R7: A search (op 2) matches a slot when its VPN equals key bits 31:13 and either its global bit is set or its ASID equals key bits 7:0. The lowest matching slot wins, and its number is written to the index register with bit 31 cleared.
- R8: A search with no match sets bit 31 of the index register and leaves the other bits unchanged.
- R9: `cmd_done` is high for exactly one cycle. Counting the cycle after acceptance as cycle 1, it is high in cycle 2 for writes and reads, in cycle i+2 for a search that hits slot i, and in cycle NUM_ENTRIES+1 for a search that misses.
- R10: While a command is in progress, register writes and `cmd_valid` are ignored.
- R11: The indexed-write (op 0) and read commands use the index register ANDed with NUM_ENTRIES-1 as the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command request, taken only in `ST_IDLE` |
| cmd_op | input | 2 | 0 write by index, 1 write by victim, 2 search, 3 read |
| cmd_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High while a command is in progress |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | 0 key, 1 even descriptor, 2 odd descriptor, 3 page mask, 4 index, 5 victim counter |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Data of the selected register (combinational) |

## Verification
The search is tried with four keys. The first matches only a global entry, which shows the global bit overriding an ASID mismatch. The second matches both that entry and a lower slot on its own ASID, which shows that the lowest slot wins. The third matches nothing, which shows bit 31 being set on top of the old index. The fourth is issued while software writes the index register mid-scan, which separates the scan result from a register write that should be ignored. Each search's latency shows how many slots were scanned. The write/read round trip uses descriptors with different global bits and a key with bits 12:8 set, which checks field stripping and rebuild. An out-of-range index checks the slot masking.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WRITE = 3'd1,
        ST_SCAN  = 3'd2,
        ST_READ  = 3'd3,
        ST_FIN   = 3'd4
    } tlb_state_e;

    localparam logic [1:0] OP_WR_IDX = 2'd0;
    localparam logic [1:0] OP_WR_RND = 2'd1;
    localparam logic [1:0] OP_PROBE  = 2'd2;
    localparam logic [1:0] OP_READ   = 2'd3;

    localparam logic [2:0] SEL_KEY  = 3'd0;
    localparam logic [2:0] SEL_LO0  = 3'd1;
    localparam logic [2:0] SEL_LO1  = 3'd2;
    localparam logic [2:0] SEL_MASK = 3'd3;
    localparam logic [2:0] SEL_IDX  = 3'd4;
    localparam logic [2:0] SEL_RND  = 3'd5;

    localparam int PAGE_SHIFT = 13;

endpackage

// File: rtl/tlb_victim_ctr.sv
module tlb_victim_ctr #(
    parameter int NUM_ENTRIES = 16,
    parameter int RAND_FLOOR  = 2,
    localparam int IW = $clog2(NUM_ENTRIES)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [IW-1:0] rnd_o
);
    localparam logic [IW-1:0] TOP = IW'(NUM_ENTRIES - 1);
    localparam logic [IW-1:0] BOT = IW'(RAND_FLOOR);

    always_ff @(posedge clk) begin
        if (rst)
            rnd_o <= TOP;
        else if (rnd_o == BOT)
            rnd_o <= TOP;
        else
            rnd_o <= rnd_o - 1'b1;
    end

    // R2: counter stays inside its window and steps down by one
    p_rand_range_r2: assert property (@(posedge clk) disable iff (rst)
        (rnd_o >= BOT) && (rnd_o <= TOP));
    p_rand_step_r2: assert property (@(posedge clk) disable iff (rst)
        (rnd_o != BOT) |=> (rnd_o == $past(rnd_o) - 1'b1));
    p_rand_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (rnd_o == BOT) |=> (rnd_o == TOP));
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
    parameter int NUM_ENTRIES = 16,
    parameter int VPN_W       = 19,
    parameter int ASID_W      = 8,
    parameter int PG_W        = 31,
    parameter int MASK_W      = 32,
    localparam int IW = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IW-1:0]     waddr,
    input  logic [VPN_W-1:0]  w_vpn,
    input  logic [ASID_W-1:0] w_asid,
    input  logic              w_g,
    input  logic [PG_W-1:0]   w_pg0,
    input  logic [PG_W-1:0]   w_pg1,
    input  logic [MASK_W-1:0] w_mask,
    input  logic [IW-1:0]     raddr,
    output logic [VPN_W-1:0]  r_vpn,
    output logic [ASID_W-1:0] r_asid,
    output logic              r_g,
    output logic [PG_W-1:0]   r_pg0,
    output logic [PG_W-1:0]   r_pg1,
    output logic [MASK_W-1:0] r_mask
);
    logic [VPN_W-1:0]  vpn_q  [NUM_ENTRIES];
    logic [ASID_W-1:0] asid_q [NUM_ENTRIES];
    logic              g_q    [NUM_ENTRIES];
    logic [PG_W-1:0]   pg0_q  [NUM_ENTRIES];
    logic [PG_W-1:0]   pg1_q  [NUM_ENTRIES];
    logic [MASK_W-1:0] mask_q [NUM_ENTRIES];

    for (genvar s = 0; s < NUM_ENTRIES; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                vpn_q[s]  <= '0;
                asid_q[s] <= '0;
                g_q[s]    <= 1'b0;
                pg0_q[s]  <= '0;
                pg1_q[s]  <= '0;
                mask_q[s] <= '0;
            end else if (we && (waddr == IW'(s))) begin
                vpn_q[s]  <= w_vpn;
                asid_q[s] <= w_asid;
                g_q[s]    <= w_g;
                pg0_q[s]  <= w_pg0;
                pg1_q[s]  <= w_pg1;
                mask_q[s] <= w_mask;
            end
        end
    end

    always_comb begin
        r_vpn  = vpn_q[raddr];
        r_asid = asid_q[raddr];
        r_g    = g_q[raddr];
        r_pg0  = pg0_q[raddr];
        r_pg1  = pg1_q[raddr];
        r_mask = mask_q[raddr];
    end
endmodule

// File: rtl/tlb_probe_cmp.sv
module tlb_probe_cmp #(
    parameter int VPN_W  = 19,
    parameter int ASID_W = 8
) (
    input  logic [VPN_W-1:0]  ent_vpn,
    input  logic [ASID_W-1:0] ent_asid,
    input  logic              ent_g,
    input  logic [VPN_W-1:0]  key_vpn,
    input  logic [ASID_W-1:0] key_asid,
    output logic              hit
);
    logic page_eq;
    logic space_ok;

    always_comb begin
        page_eq  = (ent_vpn == key_vpn);
        space_ok = ent_g || (ent_asid == key_asid);
        hit      = page_eq && space_ok;
    end
endmodule

// File: rtl/soft_tlb_ctl.sv
module soft_tlb_ctl
    import soft_tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int RAND_FLOOR  = 2,
    parameter int DATA_W      = 32,
    parameter int ASID_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    output logic              cmd_done,
    output logic              busy,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int IW    = $clog2(NUM_ENTRIES);
    localparam int VPN_W = DATA_W - PAGE_SHIFT;
    localparam int PG_W  = DATA_W - 1;
    localparam int GAP_W = PAGE_SHIFT - ASID_W;
    localparam logic [IW-1:0] LAST = IW'(NUM_ENTRIES - 1);

    tlb_state_e state_q, state_d;

    logic [DATA_W-1:0] key_q, lo0_q, lo1_q, mask_q, idx_q;
    logic [IW-1:0]     slot_q, scan_q;
    logic [IW-1:0]     rnd;
    logic              accept;
    logic              hit;

    logic              arr_we;
    logic [IW-1:0]     arr_raddr;
    logic [VPN_W-1:0]  r_vpn;
    logic [ASID_W-1:0] r_asid;
    logic              r_g;
    logic [PG_W-1:0]   r_pg0, r_pg1;
    logic [DATA_W-1:0] r_mask;

    tlb_victim_ctr #(.NUM_ENTRIES(NUM_ENTRIES), .RAND_FLOOR(RAND_FLOOR)) u_victim (
        .clk(clk), .rst(rst), .rnd_o(rnd)
    );

    tlb_entry_array #(
        .NUM_ENTRIES(NUM_ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W),
        .PG_W(PG_W), .MASK_W(DATA_W)
    ) u_array (
        .clk(clk), .rst(rst),
        .we(arr_we), .waddr(slot_q),
        .w_vpn(key_q[DATA_W-1:PAGE_SHIFT]), .w_asid(key_q[ASID_W-1:0]),
        .w_g(lo0_q[0] & lo1_q[0]),
        .w_pg0(lo0_q[DATA_W-1:1]), .w_pg1(lo1_q[DATA_W-1:1]),
        .w_mask(mask_q),
        .raddr(arr_raddr),
        .r_vpn(r_vpn), .r_asid(r_asid), .r_g(r_g),
        .r_pg0(r_pg0), .r_pg1(r_pg1), .r_mask(r_mask)
    );

    tlb_probe_cmp #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_cmp (
        .ent_vpn(r_vpn), .ent_asid(r_asid), .ent_g(r_g),
        .key_vpn(key_q[DATA_W-1:PAGE_SHIFT]), .key_asid(key_q[ASID_W-1:0]),
        .hit(hit)
    );

    assign accept = (state_q == ST_IDLE) && cmd_valid;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (cmd_op)
                        OP_WR_IDX, OP_WR_RND: state_d = ST_WRITE;
                        OP_PROBE:             state_d = ST_SCAN;
                        OP_READ:              state_d = ST_READ;
                        default:              state_d = ST_IDLE;
                    endcase
                end
            end
            ST_WRITE: state_d = ST_FIN;
            ST_READ:  state_d = ST_FIN;
            ST_SCAN:  if (hit || scan_q == LAST) state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_done  = (state_q == ST_FIN);
        busy      = (state_q != ST_IDLE);
        arr_we    = (state_q == ST_WRITE);
        arr_raddr = (state_q == ST_SCAN) ? scan_q : slot_q;
        unique case (reg_sel)
            SEL_KEY:  reg_rdata = key_q;
            SEL_LO0:  reg_rdata = lo0_q;
            SEL_LO1:  reg_rdata = lo1_q;
            SEL_MASK: reg_rdata = mask_q;
            SEL_IDX:  reg_rdata = idx_q;
            SEL_RND:  reg_rdata = DATA_W'(rnd);
            default:  reg_rdata = '0;
        endcase
    end

    // command latches and scan pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            scan_q <= '0;
        end else begin
            if (accept) begin
                slot_q <= (cmd_op == OP_WR_RND) ? rnd : idx_q[IW-1:0];
                scan_q <= '0;
            end else if (state_q == ST_SCAN && !hit && scan_q != LAST) begin
                scan_q <= scan_q + 1'b1;
            end
        end
    end

    // coprocessor registers
    always_ff @(posedge clk) begin
        if (rst) begin
            key_q  <= '0;
            lo0_q  <= '0;
            lo1_q  <= '0;
            mask_q <= '0;
            idx_q  <= {1'b1, {(DATA_W-1){1'b0}}};
        end else if (state_q == ST_IDLE) begin
            if (reg_we) begin
                unique case (reg_sel)
                    SEL_KEY:  key_q  <= reg_wdata;
                    SEL_LO0:  lo0_q  <= reg_wdata;
                    SEL_LO1:  lo1_q  <= reg_wdata;
                    SEL_MASK: mask_q <= reg_wdata;
                    SEL_IDX:  idx_q  <= reg_wdata;
                    default:  ;
                endcase
            end
        end else if (state_q == ST_READ) begin
            key_q  <= {r_vpn, {GAP_W{1'b0}}, r_asid};
            lo0_q  <= {r_pg0, r_g};
            lo1_q  <= {r_pg1, r_g};
            mask_q <= r_mask;
        end else if (state_q == ST_SCAN) begin
            if (hit)
                idx_q <= DATA_W'(scan_q);
            else if (scan_q == LAST)
                idx_q[DATA_W-1] <= 1'b1;
        end
    end

    // R9: completion pulse lasts one cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_done |=> !cmd_done);
    // R7: a hit records the scanned slot with the miss flag clear
    p_hit_index_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN && hit) |=> (idx_q == DATA_W'($past(scan_q))));
    // R8: a full scan without hit raises the miss flag
    p_miss_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN && !hit && scan_q == LAST) |=> idx_q[DATA_W-1]);
    // R10: the key register cannot move while a write or scan is under way
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WRITE || state_q == ST_SCAN || state_q == ST_FIN) |=> $stable(key_q));
endmodule

// File: tb/sim_soft_tlb_ctl.sv
module sim_soft_tlb_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 16;
    localparam int FLOOR = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        cmd_done, busy;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model
    logic [31:0] m_hi [N];
    logic [31:0] m_lo0 [N];
    logic [31:0] m_lo1 [N];
    logic [31:0] m_mask [N];
    logic        m_g [N];
    logic [31:0] m_idx;

    // scoreboard queues
    logic [2:0]  q_sel [$];
    logic [31:0] q_exp [$];
    string       q_tag [$];

    soft_tlb_ctl #(.NUM_ENTRIES(N), .RAND_FLOOR(FLOOR)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_done(cmd_done), .busy(busy), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_exp(input logic [2:0] s, input logic [31:0] e, input string tag);
        q_sel.push_back(s);
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    // monitor: pops expected items and compares against the register port
    task automatic drain();
        while (q_sel.size() > 0) begin
            logic [2:0]  s = q_sel.pop_front();
            logic [31:0] e = q_exp.pop_front();
            string       t = q_tag.pop_front();
            @(negedge clk);
            reg_sel = s;
            #1;
            check(reg_rdata === e, t, reg_rdata, e);
        end
    endtask

    task automatic wr_reg(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic issue(input logic [1:0] op, output int lat);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cmd_done && lat < 100);
    endtask

    function automatic void model_write(input int slot, input logic [31:0] hi,
                                        input logic [31:0] lo0, input logic [31:0] lo1,
                                        input logic [31:0] mask);
        logic g = lo0[0] & lo1[0];
        m_hi[slot]   = (hi & 32'hFFFF_E000) | {24'h0, hi[7:0]};
        m_g[slot]    = g;
        m_lo0[slot]  = {lo0[31:1], g};
        m_lo1[slot]  = {lo1[31:1], g};
        m_mask[slot] = mask;
    endfunction

    function automatic logic [31:0] model_probe(input logic [31:0] key, input logic [31:0] old);
        for (int i = 0; i < N; i++) begin
            if ((m_hi[i][31:13] == key[31:13]) && (m_g[i] || m_hi[i][7:0] == key[7:0]))
                return 32'(i);
        end
        return old | 32'h8000_0000;
    endfunction

    function automatic int model_lat(input logic [31:0] key);
        for (int i = 0; i < N; i++) begin
            if ((m_hi[i][31:13] == key[31:13]) && (m_g[i] || m_hi[i][7:0] == key[7:0]))
                return i + 2;
        end
        return N + 1;
    endfunction

    task automatic load_and_write(input logic [1:0] op, input logic [31:0] hi, input logic [31:0] lo0,
                                  input logic [31:0] lo1, input logic [31:0] mask, input int slot);
        int lat;
        wr_reg(3'd0, hi); wr_reg(3'd1, lo0); wr_reg(3'd2, lo1); wr_reg(3'd3, mask);
        if (op == 2'd0) begin
            wr_reg(3'd4, 32'(slot));
            m_idx = 32'(slot);
        end
        issue(op, lat);
        model_write(slot, hi, lo0, lo1, mask);
        check(lat == 2, "R9 write latency", 32'(lat), 32'd2);
    endtask

    task automatic read_back(input logic [31:0] idx_val, input string tag);
        int lat;
        int slot = int'(idx_val & 32'(N - 1));
        wr_reg(3'd0, 32'hFFFF_FFFF); wr_reg(3'd1, 32'h0); wr_reg(3'd2, 32'h0);
        wr_reg(3'd3, 32'h5A5A_5A5A);
        wr_reg(3'd4, idx_val);
        m_idx = idx_val;
        issue(2'd3, lat);
        check(lat == 2, {tag, " R9 read latency"}, 32'(lat), 32'd2);
        push_exp(3'd0, m_hi[slot],   {tag, " R6 key"});
        push_exp(3'd1, m_lo0[slot],  {tag, " R6 lo0"});
        push_exp(3'd2, m_lo1[slot],  {tag, " R6 lo1"});
        push_exp(3'd3, m_mask[slot], {tag, " R6 mask"});
        push_exp(3'd4, m_idx,        {tag, " index kept"});
        drain();
    endtask

    task automatic do_probe(input logic [31:0] key, input string tag);
        int lat;
        int elat = model_lat(key);
        wr_reg(3'd0, key);
        issue(2'd2, lat);
        m_idx = model_probe(key, m_idx);
        check(lat == elat, {tag, " R9 probe latency"}, 32'(lat), 32'(elat));
        push_exp(3'd4, m_idx, tag);
        drain();
    endtask

    initial begin
        int lat;
        logic [31:0] prev, cur;
        for (int i = 0; i < N; i++) begin
            m_hi[i] = '0; m_lo0[i] = '0; m_lo1[i] = '0; m_mask[i] = '0; m_g[i] = 1'b0;
        end
        m_idx = 32'h8000_0000;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        reg_sel = 3'd4; #1;
        check(reg_rdata === 32'h8000_0000, "R1 index reset", reg_rdata, 32'h8000_0000);
        read_back(32'h8000_0000, "R1 slot0 cleared");

        // R2: victim counter sequence, writes ignored
        @(negedge clk); reg_sel = 3'd5; #1; prev = reg_rdata;
        for (int k = 0; k < 40; k++) begin
            if (k == 20) begin
                @(negedge clk);
                reg_we = 1'b1; reg_sel = 3'd5; reg_wdata = 32'd0;
                @(posedge clk); #1; reg_we = 1'b0;
                prev = (prev == FLOOR) ? 32'(N - 1) : prev - 1;
                reg_sel = 3'd5;
            end
            @(negedge clk); reg_sel = 3'd5; #1; cur = reg_rdata;
            check(cur == ((prev == FLOOR) ? 32'(N - 1) : prev - 1), "R2 victim step", cur,
                  (prev == FLOOR) ? 32'(N - 1) : prev - 1);
            prev = cur;
        end

        // R3 R4 R6: write slot 5 with mixed global bits, key bits 12:8 set
        load_and_write(2'd0, 32'h1234_5FC7, 32'h0123_4567, 32'h89AB_CDEE, 32'h0000_6000, 5);
        // R11: index above range folds onto slot 5
        read_back(32'h0000_0015, "R3 R4 R11 slot5");

        // global entry at slot 9, same page, other ASID
        load_and_write(2'd0, 32'h1234_4033, 32'hFEDC_BA9F, 32'h0000_0041, 32'h0001_E000, 9);
        read_back(32'd9, "R3 slot9 global");
        load_and_write(2'd0, 32'hCAFE_0011, 32'h0000_00C2, 32'h0000_0104, 32'h0, 3);

        // R7: global bit overrides ASID mismatch
        do_probe(32'h1234_4055, "R7 global hit");
        // R7: lowest matching slot wins
        do_probe(32'h1234_40C7, "R7 lowest slot");
        do_probe(32'hCAFE_0011, "R7 asid hit slot3");
        // R8: miss keeps low bits, sets bit 31
        do_probe(32'h7777_0011, "R8 miss flag");
        do_probe(32'hCAFE_0012, "R8 asid mismatch miss");

        // R5: write by victim uses counter value of acceptance cycle
        begin
            int slot;
            wr_reg(3'd0, 32'h0BAD_0042); wr_reg(3'd1, 32'h0000_1003);
            wr_reg(3'd2, 32'h0000_2005); wr_reg(3'd3, 32'h0000_0000);
            @(negedge clk);
            reg_sel = 3'd5; #1;
            slot = int'(reg_rdata);
            cmd_valid = 1'b1; cmd_op = 2'd1;
            @(posedge clk); #1;
            cmd_valid = 1'b0;
            lat = 0;
            do begin @(negedge clk); lat++; end while (!cmd_done && lat < 100);
            check(lat == 2, "R5 victim write latency", 32'(lat), 32'd2);
            // R9: pulse gone next cycle
            @(negedge clk);
            check(cmd_done == 1'b0, "R9 done single cycle", 32'(cmd_done), 32'd0);
            model_write(slot, 32'h0BAD_0042, 32'h0000_1003, 32'h0000_2005, 32'h0);
            read_back(32'(slot), "R5 victim slot");
        end

        // R10: writes and commands during a scan are ignored
        wr_reg(3'd4, 32'd7);
        m_idx = 32'd7;
        wr_reg(3'd0, 32'h5555_0001);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd2;
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_op = 2'd0;
        reg_we = 1'b1; reg_sel = 3'd4; reg_wdata = 32'd2;
        repeat (4) @(posedge clk);
        #1;
        reg_sel = 3'd0; reg_wdata = 32'hDEAD_BEEF;
        @(posedge clk); #1;
        reg_we = 1'b0; cmd_valid = 1'b0;
        while (!cmd_done) @(negedge clk);
        @(negedge clk);
        m_idx = model_probe(32'h5555_0001, m_idx);
        push_exp(3'd4, m_idx, "R10 index write ignored while busy");
        push_exp(3'd0, 32'h5555_0001, "R10 key write ignored while busy");
        drain();
        @(negedge clk);
        check(busy == 1'b0, "R10 extra command ignored", 32'(busy), 32'd0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule